// File: doc/BRIEF.md
# Dual-Mode Binary Extension Field Multiplier

This block multiplies two elements of GF(2^m) held in polynomial basis. A single mode bit chooses between the plain product A·B and the product A·B², both reduced modulo a field polynomial. The polynomial's coefficients arrive on an input at run time, so one instance can serve any field it is given. The array of cells is sized for a largest degree `M`. A field-size input `m` (1 ≤ m ≤ M) makes the lower m×m corner of the array act as an m-bit multiplier.

The array is a chain of `M` identical columns. Each column adds the running shifted copy of A into the partial product when its bit of B is set. It then multiplies that copy by α for A·B, or by α² for A·B². The α² step needs the coefficients of α^(m+1), and these are derived once from the polynomial. Columns at or above `m` see a zero B bit, so they pass the partial product through unchanged. The result is registered, so it appears one clock after its inputs. A typical user is a decoder datapath that builds division or exponentiation by repeated square-and-multiply.

Top module: `gf_dual_mult`

## Requirements
- R1: While `rst_n` is low the output is 0. Otherwise `prod_out` shows the result for the inputs sampled at the previous rising edge of `clk`, which is a latency of one cycle.
- R2: With `sq_mode_in` = 0 the output is A·B mod f(x). Here f(x) = x^m + Σ poly_in[i]·x^i for i < m, and bit i of each operand is the coefficient of x^i.
- R3: With `sq_mode_in` = 1 the output is A·B² mod f(x), for the same operand and polynomial encoding.
- R4: The polynomial is taken from `poly_in` at run time. The same operands under two different polynomials give the product in each field.
- R5: The field size is `fsize_in` = m. Bits at index m and above of `a_in`, `b_in` and `poly_in` do not affect the result.
- R6: Output bits at index m and above are 0.
- R7: When `fsize_in` is 0 or greater than `M`, the output is 0.
- R8: A zero operand gives a zero result, and B = 1 gives A (the operand masked to m bits) in both modes.
- R9: The smallest field, m = 1, behaves as GF(2) in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| a_in | input | M | Operand A, bit i is the coefficient of x^i |
| b_in | input | M | Operand B, same encoding |
| poly_in | input | M | Low coefficients f_0..f_{m-1} of the field polynomial |
| fsize_in | input | $clog2(M+1) | Field degree m |
| sq_mode_in | input | 1 | 0: A·B, 1: A·B² |
| prod_out | output | M | Registered result |

## Verification
The bound checker checks several properties on every cycle against the inputs of the previous cycle. The result must have no bits at or above m. An out-of-range field size must give zero. A zero operand must give zero. A unit B must return A in either mode. The field arithmetic itself can only be shown by the bench's scenarios. These cover every operand pair in GF(2^4), random pairs in GF(2^8), a change of polynomial, junk in the high input bits and the one-bit field, each compared with a bit-serial model.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Operation selected by the mode input
    typedef enum logic {
        GFM_MUL    = 1'b0,
        GFM_MUL_SQ = 1'b1
    } gfm_op_e;

    // Width of the field-size input for a given largest degree
    function automatic int unsigned gfm_size_w(input int unsigned max_deg);
        return $clog2(max_deg + 1);
    endfunction
endpackage

// File: rtl/gf_field_ctrl.sv
module gf_field_ctrl
    import gfm_pkg::*;
#(
    parameter int unsigned M  = 8,
    localparam int unsigned MW = gfm_size_w(M)
) (
    input  logic [MW-1:0] fsize_i,
    input  logic          sq_mode_i,
    input  logic [M-1:0]  poly_i,
    output logic          field_ok_o,
    output logic [M-1:0]  row_en_o,
    output logic [M-1:0]  f_row_o,
    output logic [M-1:0]  f1_row_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic f_top;

    always_comb begin
        field_ok_o = (fsize_i != '0) && (int'(fsize_i) <= int'(M));
        f_top      = 1'b0;
        row_en_o   = '0;
        for (int k = 0; k < int'(M); k++) begin
            row_en_o[k] = field_ok_o && (k < int'(fsize_i));
            if (k + 1 == int'(fsize_i)) begin
                f_top = poly_i[k];
            end
        end
        // coefficients of alpha^m inside the active rows
        f_row_o  = poly_i & row_en_o;
        // alpha^(m+1) = f_{m-1}*alpha^m + alpha * (alpha^m without its top term)
        f1_row_o = (({M{f_top}} & f_row_o) ^ (f_row_o << 1))
                   & row_en_o & {M{sq_mode_i == GFM_MUL_SQ}};
    end
endmodule

// File: rtl/gf_step_column.sv
module gf_step_column
    import gfm_pkg::*;
#(
    parameter int unsigned M  = 8,
    localparam int unsigned MW = gfm_size_w(M)
) (
    input  logic [M-1:0]  q_i,
    input  logic [M-1:0]  p_i,
    input  logic          b_bit_i,
    input  logic [MW-1:0] fsize_i,
    input  logic          sq_mode_i,
    input  logic [M-1:0]  row_en_i,
    input  logic [M-1:0]  f_row_i,
    input  logic [M-1:0]  f1_row_i,
    output logic [M-1:0]  q_o,
    output logic [M-1:0]  p_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic c_hi;
    logic c_lo;

    // carries come from the top row of the active field, not row M-1
    always_comb begin
        c_hi = 1'b0;
        c_lo = 1'b0;
        for (int k = 0; k < int'(M); k++) begin
            if (k + 1 == int'(fsize_i)) c_hi = q_i[k];
            if (k + 2 == int'(fsize_i)) c_lo = q_i[k];
        end
    end

    always_comb begin
        p_o = p_i ^ (q_i & {M{b_bit_i}});
        if (sq_mode_i == GFM_MUL_SQ) begin
            q_o = ({M{c_hi}} & f1_row_i) ^ ({M{c_lo}} & f_row_i) ^ (q_i << 2);
        end else begin
            q_o = ({M{c_hi}} & f_row_i) ^ (q_i << 1);
        end
        q_o = q_o & row_en_i;
    end
endmodule

// File: rtl/gf_cell_array.sv
module gf_cell_array
    import gfm_pkg::*;
#(
    parameter int unsigned M  = 8,
    localparam int unsigned MW = gfm_size_w(M)
) (
    input  logic [M-1:0]  a_i,
    input  logic [M-1:0]  b_i,
    input  logic [MW-1:0] fsize_i,
    input  logic          sq_mode_i,
    input  logic [M-1:0]  row_en_i,
    input  logic [M-1:0]  f_row_i,
    input  logic [M-1:0]  f1_row_i,
    output logic [M-1:0]  prod_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [M-1:0] q_w [M+1];
    logic [M-1:0] p_w [M+1];
    logic [M-1:0] b_act;

    assign b_act  = b_i & row_en_i;
    assign q_w[0] = a_i & row_en_i;
    assign p_w[0] = '0;

    for (genvar j = 0; j < int'(M); j++) begin : g_col
        gf_step_column #(.M(M)) u_col (
            .q_i      (q_w[j]),
            .p_i      (p_w[j]),
            .b_bit_i  (b_act[j]),
            .fsize_i  (fsize_i),
            .sq_mode_i(sq_mode_i),
            .row_en_i (row_en_i),
            .f_row_i  (f_row_i),
            .f1_row_i (f1_row_i),
            .q_o      (q_w[j+1]),
            .p_o      (p_w[j+1])
        );
    end

    assign prod_o = p_w[M] & row_en_i;
endmodule

// File: rtl/gf_dual_mult.sv
module gf_dual_mult
    import gfm_pkg::*;
#(
    parameter int unsigned M  = 8,
    localparam int unsigned MW = gfm_size_w(M)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [M-1:0]  a_in,
    input  logic [M-1:0]  b_in,
    input  logic [M-1:0]  poly_in,
    input  logic [MW-1:0] fsize_in,
    input  logic          sq_mode_in,
    output logic [M-1:0]  prod_out
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [M-1:0] prod;
    } state_t;

    state_t       state_d;
    state_t       state_q;
    logic         field_ok;
    logic [M-1:0] row_en;
    logic [M-1:0] f_row;
    logic [M-1:0] f1_row;
    logic [M-1:0] prod_w;

    gf_field_ctrl #(.M(M)) u_ctrl (
        .fsize_i   (fsize_in),
        .sq_mode_i (sq_mode_in),
        .poly_i    (poly_in),
        .field_ok_o(field_ok),
        .row_en_o  (row_en),
        .f_row_o   (f_row),
        .f1_row_o  (f1_row)
    );

    gf_cell_array #(.M(M)) u_array (
        .a_i      (a_in),
        .b_i      (b_in),
        .fsize_i  (fsize_in),
        .sq_mode_i(sq_mode_in),
        .row_en_i (row_en),
        .f_row_i  (f_row),
        .f1_row_i (f1_row),
        .prod_o   (prod_w)
    );

    always_comb begin
        state_d      = state_q;
        state_d.prod = field_ok ? prod_w : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign prod_out = state_q.prod;
endmodule

// File: rtl/gf_dual_mult_chk.sv
module gf_dual_mult_chk
    import gfm_pkg::*;
#(
    parameter int unsigned M  = 8,
    localparam int unsigned MW = gfm_size_w(M)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [M-1:0]  a_in,
    input logic [M-1:0]  b_in,
    input logic [MW-1:0] fsize_in,
    input logic [M-1:0]  prod_out
);
    timeunit 1ns;
    timeprecision 1ps;

    logic          primed_q;
    logic [M-1:0]  a_q;
    logic [M-1:0]  b_q;
    logic [MW-1:0] fs_q;
    logic          ok_q;
    logic [M-1:0]  msk_q;

    function automatic logic [M-1:0] size_mask(input logic [MW-1:0] s);
        logic [M-1:0] r;
        r = '0;
        for (int k = 0; k < int'(M); k++) r[k] = (k < int'(s));
        if (s == '0 || int'(s) > int'(M)) r = '0;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            a_q      <= '0;
            b_q      <= '0;
            fs_q     <= '0;
        end else begin
            primed_q <= 1'b1;
            a_q      <= a_in;
            b_q      <= b_in;
            fs_q     <= fsize_in;
        end
    end

    assign msk_q = size_mask(fs_q);
    assign ok_q  = (fs_q != '0) && (int'(fs_q) <= int'(M));

    // R6
    hi_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> ((prod_out & ~msk_q) == '0));

    // R7
    bad_size_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !ok_q) |-> (prod_out == '0));

    // R8
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && (((a_q & msk_q) == '0) || ((b_q & msk_q) == '0))) |-> (prod_out == '0));

    // R8
    unit_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && ok_q && ((b_q & msk_q) == M'(1))) |-> (prod_out == (a_q & msk_q)));
endmodule

bind gf_dual_mult gf_dual_mult_chk #(.M(M)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .fsize_in(fsize_in),
    .prod_out(prod_out)
);

// File: tb/gf_dual_mult_test.sv
module gf_dual_mult_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned M  = 8;
    localparam int unsigned MW = $clog2(M + 1);

    typedef struct {
        logic [M-1:0] val;
        string        tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [M-1:0]  a_in = '0;
    logic [M-1:0]  b_in = '0;
    logic [M-1:0]  poly_in = '0;
    logic [MW-1:0] fsize_in = '0;
    logic          sq_mode_in = 1'b0;
    logic [M-1:0]  prod_out;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    gf_dual_mult #(.M(M)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_in      (a_in),
        .b_in      (b_in),
        .poly_in   (poly_in),
        .fsize_in  (fsize_in),
        .sq_mode_in(sq_mode_in),
        .prod_out  (prod_out)
    );

    always #2 clk = ~clk;

    // bit-serial Horner model: shift left, fold x^m back, add A when b bit set
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b,
                                             input logic [M-1:0] f, input int m);
        logic [M-1:0] r;
        logic [M-1:0] msk;
        logic         top;
        if (m < 1 || m > int'(M)) return '0;
        msk = '0;
        for (int k = 0; k < m; k++) msk[k] = 1'b1;
        r = '0;
        for (int i = m - 1; i >= 0; i--) begin
            top = r[m-1];
            r   = (r << 1) & msk;
            if (top) r = r ^ (f & msk);
            if (b[i]) r = r ^ (a & msk);
        end
        return r;
    endfunction

    function automatic logic [M-1:0] ref_op(input logic [M-1:0] a, input logic [M-1:0] b,
                                            input logic [M-1:0] f, input int m, input logic sq);
        if (sq) return ref_mul(a, ref_mul(b, b, f, m), f, m);
        return ref_mul(a, b, f, m);
    endfunction

    task automatic apply(input logic [M-1:0] a, input logic [M-1:0] b, input logic [M-1:0] f,
                         input int m, input logic sq, input string tag);
        exp_t e;
        @(negedge clk);
        a_in       = a;
        b_in       = b;
        poly_in    = f;
        fsize_in   = MW'(m);
        sq_mode_in = sq;
        e.val = ref_op(a, b, f, m, sq);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: result of inputs driven before an edge is valid just after it
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_cmp++;
                if (prod_out !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: a=%h b=%h f=%h m=%0d sq=%0b got %h expected %h",
                             e.tag, a_in, b_in, poly_in, fsize_in, sq_mode_in, prod_out, e.val);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: output held at zero in reset with nonzero inputs
        a_in = 8'h0b; b_in = 8'h07; poly_in = 8'h1d; fsize_in = 4'd8;
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (prod_out !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: got %h expected 00", prod_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R4: x^3 * x in two fields of degree 4
        apply(8'h08, 8'h02, 8'h03, 4, 1'b0, "R2 x^4 folds to x+1");
        apply(8'h08, 8'h02, 8'h09, 4, 1'b0, "R4 alternate polynomial");
        apply(8'h08, 8'h02, 8'h09, 4, 1'b1, "R4 alternate polynomial sq");

        // R2 / R3: every pair in GF(2^4), f = x^4 + x + 1
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(M'(a), M'(b), 8'h03, 4, 1'b0, "R2 exhaustive m4");
                apply(M'(a), M'(b), 8'h03, 4, 1'b1, "R3 exhaustive m4");
            end
        end

        // R2 / R3: random pairs in GF(2^8), f = x^8 + x^4 + x^3 + x^2 + 1
        for (int n = 0; n < 300; n++) begin
            logic [M-1:0] ra;
            logic [M-1:0] rb;
            ra = M'($urandom);
            rb = M'($urandom);
            apply(ra, rb, 8'h1d, 8, 1'b0, "R2 random m8");
            apply(ra, rb, 8'h1d, 8, 1'b1, "R3 random m8");
        end

        // R5 / R6: junk above bit m must not matter, high result bits zero
        apply(8'ha8, 8'h52, 8'hf3, 4, 1'b0, "R5 high input bits ignored");
        apply(8'hfe, 8'hb7, 8'he3, 4, 1'b1, "R5 high input bits ignored sq");
        apply(8'h3f, 8'h2d, 8'h25, 6, 1'b0, "R6 degree 6 field");
        apply(8'h3f, 8'h2d, 8'h25, 6, 1'b1, "R6 degree 6 field sq");

        // R7: out-of-range sizes
        apply(8'hff, 8'hff, 8'h1d, 0, 1'b0, "R7 size zero");
        apply(8'hff, 8'hff, 8'h1d, 9, 1'b1, "R7 size above max");
        apply(8'hff, 8'hff, 8'h1d, 15, 1'b0, "R7 size fifteen");

        // R8: zero and unit operands
        apply(8'h00, 8'h9c, 8'h1d, 8, 1'b1, "R8 zero A");
        apply(8'h9c, 8'h00, 8'h1d, 8, 1'b0, "R8 zero B");
        apply(8'h9c, 8'h01, 8'h1d, 8, 1'b1, "R8 unit B sq");
        apply(8'h9c, 8'h01, 8'h1d, 8, 1'b0, "R8 unit B");

        // R9: one-bit field
        apply(8'h01, 8'h01, 8'h01, 1, 1'b0, "R9 m1 1*1");
        apply(8'h01, 8'h01, 8'h01, 1, 1'b1, "R9 m1 1*1^2");
        apply(8'h01, 8'h00, 8'h01, 1, 1'b1, "R9 m1 1*0");
        apply(8'hff, 8'hff, 8'hff, 1, 1'b0, "R9 m1 junk high");

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule